// File: doc/BRIEF.md
# SEC-DED Codec for an Eight-Bit Memory Word

This block protects one byte of memory data with a single-error-correcting, double-error-detecting Hamming code. Its write side is purely combinational. A byte goes in and a 13-bit storage word comes out, made of twelve Hamming-ordered bits and one overall even-parity bit.

On the read side, a fetched 13-bit word is presented together with a valid strobe. The block then does three things:

- It recomputes the check bits and forms a syndrome.
- It combines the syndrome with the overall parity to classify the fetch.
- It repairs a single failing data bit where that is possible.

The repaired byte and a one-hot status are registered and appear one clock later, together with an output valid. The four status outcomes are:

- **clean**: no error.
- **fixed**: a data bit was inverted.
- **check**: a single error hit a protection bit, so the data is untouched.
- **uncorrectable**: the data is returned exactly as fetched.

A memory controller places the encoder in its write path and the decoder in its read path. It uses the status to decide between forwarding the data and raising an error.

Top module: `secded8_codec`

## Requirements
- R1: Storage word bit p-1 holds Hamming position p (p = 1..12). Data bits d0..d7 sit at positions 3, 5, 6, 7, 9, 10, 11, 12 in that order, and check bits sit at positions 1, 2, 4, 8. Bit 12 is set so that all 13 bits have even parity.
- R2: The check bit at position 2^j is the XOR of every data position whose binary number has bit j set. So position 1 = d0^d1^d3^d4^d6, position 2 = d0^d2^d3^d5^d6, position 4 = d1^d2^d3^d7, and position 8 = d4^d5^d6^d7.
- R3: A fetched word that is an unaltered encoding is reported as clean, and its original byte is returned.
- R4: A fetched word with exactly one flipped data position is reported as fixed, and the original byte is returned.
- R5: A single flip at position 1, 2, 4 or 8, or in bit 12, is reported as check, and the byte is returned unchanged.
- R6: A fetched word with two flipped bits is reported as uncorrectable. Its data field is returned as fetched, with no bit inverted.
- R7: Odd overall parity combined with a syndrome of 13, 14 or 15 is reported as uncorrectable, and the data field is returned as fetched.
- R8: outValid is high in the cycle after each cycle with inValid high, and low otherwise. The result belongs to the word sampled at that edge.
- R9: While outValid is high, exactly one of outClean, outFixed, outCheck and outUncorr is high. While outValid is low, all four are low.
- R10: A cycle without inValid leaves outData unchanged, whatever inWord holds.
- R11: After reset, outValid, the four status flags and outData are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encData | input | 8 | Byte to encode |
| encWord | output | 13 | Encoded storage word (combinational) |
| inValid | input | 1 | Fetched word present this cycle |
| inWord | input | 13 | Fetched storage word |
| outValid | output | 1 | Registered result valid |
| outData | output | 8 | Corrected or passed-through byte |
| outClean | output | 1 | No error found |
| outFixed | output | 1 | Single data-bit error corrected |
| outCheck | output | 1 | Single error in a protection bit |
| outUncorr | output | 1 | Uncorrectable error |

## Verification
The properties rely on encData and inWord being driven to known values from time zero. They also treat an error pattern as arbitrary: the parity-based properties claim only what overall parity alone can decide, namely that even parity yields clean or uncorrectable and odd parity never yields clean.

The stimulus keeps the injected error patterns within the classes the requirements define: single flips in every bit, pairs of flips, and chosen triples whose syndrome lies above 12. It avoids triples that alias to a lower syndrome, whose outcome is a miscorrection that the code cannot see.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_CHECK  = 2'd2,
    ST_UNCORR = 2'd3
  } decStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       fixData;
    decStatus_e status;
  } decCtrl_t;

  // smallest k with 2^k >= d + k + 1
  function automatic int chkBits(int d);
    int k;
    k = 1;
    while ((1 << k) < d + k + 1) k++;
    return k;
  endfunction

  // Hamming position of data bit k: k-th position that is not a power of two
  function automatic int dataPos(int k);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == k) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
#(
  parameter int CHK_W = 4,
  parameter int HAM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CHK_W-1:0] syndrome,
  input  logic             parityErr,
  output decCtrl_t         ctrlStrb,
  output logic             outValid
);

  logic synNz;
  logic synSingle;
  logic synInRange;

  assign synNz      = |syndrome;
  assign synSingle  = ($countones(syndrome) == 1);
  assign synInRange = (int'(syndrome) <= HAM_W);

  always_comb begin
    ctrlStrb.load    = inValid;
    ctrlStrb.fixData = 1'b0;
    ctrlStrb.status  = ST_CLEAN;
    if (!synNz) begin
      // only the overall parity bit can be wrong here
      ctrlStrb.status = parityErr ? ST_CHECK : ST_CLEAN;
    end else if (!parityErr) begin
      ctrlStrb.status = ST_UNCORR;
    end else if (synSingle) begin
      ctrlStrb.status = ST_CHECK;
    end else if (!synInRange) begin
      ctrlStrb.status = ST_UNCORR;
    end else begin
      ctrlStrb.status  = ST_FIXED;
      ctrlStrb.fixData = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  parameter int HAM_W  = 12,
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  output logic [WORD_W-1:0] encWord,
  input  logic [WORD_W-1:0] inWord,
  input  decCtrl_t          ctrlStrb,
  output logic [CHK_W-1:0]  syndrome,
  output logic              parityErr,
  output logic [DATA_W-1:0] outData,
  output decStatus_e        outStatus
);

  function automatic logic [HAM_W:1] coverMask(int j);
    logic [HAM_W:1] m;
    for (int p = 1; p <= HAM_W; p++) m[p] = ((p >> j) & 1) != 0;
    return m;
  endfunction

  // ---------------- encoder ----------------
  logic [HAM_W:1]   dataSpread;
  logic [CHK_W-1:0] encChk;
  logic [HAM_W:1]   encHam;

  for (genvar k = 0; k < DATA_W; k++) begin : g_spread
    localparam int POS = dataPos(k);
    assign dataSpread[POS] = encData[k];
  end

  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    localparam int CPOS = 1 << j;
    localparam logic [HAM_W:1] MASK = coverMask(j);
    assign dataSpread[CPOS] = 1'b0;
    assign encChk[j]        = ^(dataSpread & MASK);
  end

  always_comb begin
    encHam = dataSpread;
    for (int j = 0; j < CHK_W; j++) encHam[1 << j] = encChk[j];
  end

  assign encWord = {^encHam, encHam};

  // ---------------- decoder ----------------
  logic [HAM_W:1]    rxHam;
  logic [HAM_W:1]    flipMask;
  logic [HAM_W:1]    fixHam;
  logic [DATA_W-1:0] decData;

  assign rxHam     = inWord[HAM_W-1:0];
  assign parityErr = ^inWord;

  for (genvar j = 0; j < CHK_W; j++) begin : g_syn
    localparam logic [HAM_W:1] MASK = coverMask(j);
    assign syndrome[j] = ^(rxHam & MASK);
  end

  always_comb begin
    for (int p = 1; p <= HAM_W; p++)
      flipMask[p] = ctrlStrb.fixData && (int'(syndrome) == p);
  end

  assign fixHam = rxHam ^ flipMask;

  for (genvar k = 0; k < DATA_W; k++) begin : g_gather
    localparam int POS = dataPos(k);
    assign decData[k] = fixHam[POS];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData   <= '0;
      outStatus <= ST_CLEAN;
    end else if (ctrlStrb.load) begin
      outData   <= decData;
      outStatus <= ctrlStrb.status;
    end
  end

endmodule

// File: rtl/secded8_codec.sv
module secded8_codec
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W  = chkBits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W,
  localparam int WORD_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  output logic [WORD_W-1:0] encWord,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outClean,
  output logic              outFixed,
  output logic              outCheck,
  output logic              outUncorr
);

  decCtrl_t         ctrlStrb;
  logic [CHK_W-1:0] syndrome;
  logic             parityErr;
  decStatus_e       outStatus;

  secded_ctrl #(.CHK_W(CHK_W), .HAM_W(HAM_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .syndrome  (syndrome),
    .parityErr (parityErr),
    .ctrlStrb  (ctrlStrb),
    .outValid  (outValid)
  );

  secded_datapath #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .HAM_W  (HAM_W),
    .WORD_W (WORD_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .encData   (encData),
    .encWord   (encWord),
    .inWord    (inWord),
    .ctrlStrb  (ctrlStrb),
    .syndrome  (syndrome),
    .parityErr (parityErr),
    .outData   (outData),
    .outStatus (outStatus)
  );

  assign outClean  = outValid && (outStatus == ST_CLEAN);
  assign outFixed  = outValid && (outStatus == ST_FIXED);
  assign outCheck  = outValid && (outStatus == ST_CHECK);
  assign outUncorr = outValid && (outStatus == ST_UNCORR);

endmodule

// File: rtl/secded_chk.sv
module secded_chk #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] encData,
  input logic [WORD_W-1:0] encWord,
  input logic              inValid,
  input logic [WORD_W-1:0] inWord,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outClean,
  input logic              outFixed,
  input logic              outCheck,
  input logic              outUncorr
);

  logic [3:0] flags;
  assign flags = {outClean, outFixed, outCheck, outUncorr};

  assert_enc_even_R1: assert property (@(posedge clk) disable iff (!rstN)
    (^encWord) == 1'b0);

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_flags_one_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(flags) == 1));

  assert_flags_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (flags == 4'b0000));

  assert_roundtrip_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inWord == encWord) |=> (outClean && outData == $past(encData)));

  assert_odd_never_clean_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (^inWord)) |=> !outClean);

  assert_even_clean_or_bad_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !(^inWord)) |=> (outClean || outUncorr));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));

endmodule

bind secded8_codec secded_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .encData   (encData),
  .encWord   (encWord),
  .inValid   (inValid),
  .inWord    (inWord),
  .outValid  (outValid),
  .outData   (outData),
  .outClean  (outClean),
  .outFixed  (outFixed),
  .outCheck  (outCheck),
  .outUncorr (outUncorr)
);

// File: tb/secded8_codec_tb_top.sv
`timescale 1ns/1ps
module secded8_codec_tb_top;

  localparam logic [3:0] F_CLEAN  = 4'b1000;
  localparam logic [3:0] F_FIXED  = 4'b0100;
  localparam logic [3:0] F_CHECK  = 4'b0010;
  localparam logic [3:0] F_UNCORR = 4'b0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  encData = '0;
  logic [12:0] encWord;
  logic        inValid = 1'b0;
  logic [12:0] inWord = '0;
  logic        outValid;
  logic [7:0]  outData;
  logic        outClean, outFixed, outCheck, outUncorr;

  int compared = 0;
  int mismatched = 0;
  logic [11:0] expQ[$];
  string       tagQ[$];
  logic [7:0]  lastData = '0;

  always #2.5 clk = ~clk;

  secded8_codec dut_i (
    .clk(clk), .rstN(rstN), .encData(encData), .encWord(encWord),
    .inValid(inValid), .inWord(inWord), .outValid(outValid), .outData(outData),
    .outClean(outClean), .outFixed(outFixed), .outCheck(outCheck), .outUncorr(outUncorr)
  );

  // independent encoding from the requirement formulas
  function automatic logic [12:0] benchEncode(logic [7:0] d);
    logic [12:0] w;
    w[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    w[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    w[2]  = d[0];
    w[3]  = d[1] ^ d[2] ^ d[3] ^ d[7];
    w[4]  = d[1];
    w[5]  = d[2];
    w[6]  = d[3];
    w[7]  = d[4] ^ d[5] ^ d[6] ^ d[7];
    w[8]  = d[4];
    w[9]  = d[5];
    w[10] = d[6];
    w[11] = d[7];
    w[12] = ^w[11:0];
    return w;
  endfunction

  function automatic logic [7:0] fieldOf(logic [12:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic sendWord(logic [12:0] w, logic [7:0] d, logic [3:0] f, string tag);
    @(negedge clk);
    inValid = 1'b1;
    inWord  = w;
    expQ.push_back({d, f});
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8", "unexpected outValid", 32'(outValid), 32'd0);
      end else begin
        logic [11:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outData == e[11:4], t, "data", 32'(outData), 32'(e[11:4]));
        check({outClean, outFixed, outCheck, outUncorr} == e[3:0], t, "flags",
              32'({outClean, outFixed, outCheck, outUncorr}), 32'(e[3:0]));
        lastData = e[11:4];
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (8000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] pats[6];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81};

    repeat (3) @(negedge clk);
    // R11 reset state
    check({outValid, outClean, outFixed, outCheck, outUncorr} == 5'b0, "R11", "flags in reset",
          32'({outValid, outClean, outFixed, outCheck, outUncorr}), 32'd0);
    check(outData == 8'h00, "R11", "data in reset", 32'(outData), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 6; i++) begin
      logic [7:0]  d;
      logic [12:0] w;
      d = pats[i];
      w = benchEncode(d);
      @(negedge clk);
      encData = d;
      #1;
      check(encWord == w, "R1", "encoded word", 32'(encWord), 32'(w));
      check({encWord[7], encWord[3], encWord[1], encWord[0]} == {w[7], w[3], w[1], w[0]},
            "R2", "check bits", 32'({encWord[7], encWord[3], encWord[1], encWord[0]}),
            32'({w[7], w[3], w[1], w[0]}));

      sendWord(w, d, F_CLEAN, "R3");
      for (int b = 0; b < 13; b++) begin
        int pos;
        pos = b + 1;
        if (b == 12 || (pos & (pos - 1)) == 0)
          sendWord(w ^ (13'd1 << b), d, F_CHECK, "R5");
        else
          sendWord(w ^ (13'd1 << b), d, F_FIXED, "R4");
      end
      idle();
      for (int b = 0; b < 13; b++) begin
        logic [12:0] wb;
        wb = w ^ (13'd1 << b) ^ (13'd1 << ((b + 5) % 13));
        sendWord(wb, fieldOf(wb), F_UNCORR, "R6");
      end
      idle();
      // triples with syndrome above 12 and odd parity
      sendWord(w ^ 13'b0000010001001, d, F_UNCORR, "R7");   // positions 1,4,8 -> 13
      sendWord(w ^ 13'b0000010001010, d, F_UNCORR, "R7");   // positions 2,4,8 -> 14
      begin
        logic [12:0] wt;
        wt = w ^ 13'b0000100010100;                         // positions 3,5,9 -> 15
        sendWord(wt, fieldOf(wt), F_UNCORR, "R7");
      end
      idle();
    end

    // R10 hold with inValid low and changing inWord
    sendWord(benchEncode(8'h96), 8'h96, F_CLEAN, "R3");
    @(negedge clk);
    inValid = 1'b0;
    inWord  = 13'h1FFF;
    @(negedge clk);
    inWord  = 13'h0AAA;
    check(outValid == 1'b0, "R8", "valid after idle", 32'(outValid), 32'd0);
    check(outData == 8'h96, "R10", "held data", 32'(outData), 32'h96);
    check({outClean, outFixed, outCheck, outUncorr} == 4'b0, "R9", "flags idle",
          32'({outClean, outFixed, outCheck, outUncorr}), 32'd0);
    @(negedge clk);
    check(outData == lastData, "R10", "held data 2", 32'(outData), 32'(lastData));
    check(expQ.size() == 0, "R8", "queue drained", 32'(expQ.size()), 32'd0);

    summary();
    $finish;
  end

endmodule